// File: doc/BRIEF.md
# Cascadable Priority Encoder with Status

The block turns a wide vector of request lines into the position of the highest-numbered active line. It also gives two status flags. `gs_o` says that the block is enabled and has found at least one request. `eo_o` says that the block is enabled and found none, so a further encoder of lower priority may be enabled from it. With the default parameters the block takes 32 request lines and gives a 5-bit index.

Internally the block is a chain of identical narrow encoder slices, eight lines each by default. The slice covering the top group of lines takes the block enable. Every slice hands its own enable-out down to the slice for the next lower group. A slice that finds a request therefore blocks all slices below it, and only one slice can ever report a hit. The lower index bits are the OR of all slice indices, because idle slices drive zeros. The upper index bits name the slice that reports a hit.

The block is purely combinational. It has no clock and no reset, and its outputs follow the inputs within the same evaluation. It can be placed inside any pipeline stage. It can also be cascaded further, by driving `en_i` of one instance from `eo_o` of the instance with higher priority.

Top module: `prienc_cascade`

## Requirements
- R1: With `en_i` = 0, `idx_o` = 0, `gs_o` = 0 and `eo_o` = 0 for every value of `req_i`.
- R2: With `en_i` = 1 and `req_i` all zero, `idx_o` = 0, `gs_o` = 0 and `eo_o` = 1.
- R3: With `en_i` = 1 and at least one bit of `req_i` set, `gs_o` = 1 and `eo_o` = 0. `gs_o` and `eo_o` are never 1 at the same time.
- R4: With `en_i` = 1 and `req_i` nonzero, `idx_o` equals the bit position of the highest set bit of `req_i` (bit 31 wins over every lower bit).
- R5: `idx_o[4:3]` names the group of the winning bit: 3 for bits 31..24, 2 for bits 23..16, 1 for bits 15..8 and 0 for bits 7..0. `idx_o[2:0]` is the winning bit's position within its group. Requests in groups below the winning group have no effect on any output.
- R6: When exactly one request bit i is set and `en_i` = 1, `idx_o` = i, for every i from 0 to 31.
- R7: The outputs are a combinational function of `en_i` and `req_i`. A new input value is reflected at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Block enable; drives the slice for the top group |
| req_i | input | 32 | Request lines; the higher bit number has priority |
| idx_o | output | 5 | Position of the highest active request; zero when there is no hit |
| gs_o | output | 1 | Enabled and at least one request found |
| eo_o | output | 1 | Enabled and no request found; enable for a lower-priority encoder |

## Verification
Each fault in the enable chain or in the group merge shows at the ports at once, in the same evaluation as the input pattern that exposes it. A broken link in the chain shows in one of two ways. If a lower slice is not blocked, `idx_o` is wrong whenever requests sit in two groups. If a slice that should run is cut off, the lowest-group-only patterns give the wrong result and `eo_o` is wrong. The single-bit sweep and the exhaustive patterns for each slice expose a wrong position inside a slice or a wrong group code. The random vectors with several bits spread over the groups expose priority inversions between slices.

// File: rtl/prienc_pkg.sv
package prienc_pkg;
  // Default geometry of the cascade
  localparam int DEF_SLICE_W    = 8;
  localparam int DEF_NUM_SLICES = 4;
endpackage

// File: rtl/prienc_slice.sv
module prienc_slice #(
  parameter int SLICE_W = prienc_pkg::DEF_SLICE_W,
  localparam int SIDX_W = $clog2(SLICE_W)
) (
  input  logic               en_i,
  input  logic [SLICE_W-1:0] req_i,
  output logic [SIDX_W-1:0]  idx_o,
  output logic               gs_o,
  output logic               eo_o
);
  logic [SIDX_W-1:0] hit_pos;
  logic              any_req;

  always_comb begin
    hit_pos = '0;
    for (int i = 0; i < SLICE_W; i++) begin
      if (req_i[i]) hit_pos = SIDX_W'(i);
    end
  end

  assign any_req = |req_i;
  assign idx_o   = en_i ? hit_pos : '0;
  assign gs_o    = en_i & any_req;
  assign eo_o    = en_i & ~any_req;
endmodule

// File: rtl/prienc_merge.sv
module prienc_merge #(
  parameter int NUM_SLICES = prienc_pkg::DEF_NUM_SLICES,
  parameter int SIDX_W     = 3,
  localparam int GRP_W     = $clog2(NUM_SLICES),
  localparam int OUT_W     = GRP_W + SIDX_W
) (
  input  logic [NUM_SLICES-1:0]             gs_i,
  input  logic [NUM_SLICES-1:0][SIDX_W-1:0] idx_i,
  output logic [OUT_W-1:0]                  idx_o,
  output logic                              gs_o
);
  logic [GRP_W-1:0]  grp;
  logic [SIDX_W-1:0] low;

  always_comb begin
    grp = '0;
    low = '0;
    for (int g = 0; g < NUM_SLICES; g++) begin
      if (gs_i[g]) grp = grp | GRP_W'(g);
      low = low | idx_i[g];
    end
  end

  assign idx_o = {grp, low};
  assign gs_o  = |gs_i;
endmodule

// File: rtl/prienc_cascade.sv
module prienc_cascade #(
  parameter int SLICE_W    = prienc_pkg::DEF_SLICE_W,
  parameter int NUM_SLICES = prienc_pkg::DEF_NUM_SLICES,
  localparam int REQ_W     = SLICE_W * NUM_SLICES,
  localparam int SIDX_W    = $clog2(SLICE_W),
  localparam int OUT_W     = $clog2(NUM_SLICES) + SIDX_W
) (
  input  logic             en_i,
  input  logic [REQ_W-1:0] req_i,
  output logic [OUT_W-1:0] idx_o,
  output logic             gs_o,
  output logic             eo_o
);
  logic [NUM_SLICES-1:0]             sl_en;
  logic [NUM_SLICES-1:0]             sl_gs;
  logic [NUM_SLICES-1:0]             sl_eo;
  logic [NUM_SLICES-1:0][SIDX_W-1:0] sl_idx;

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    // enable chain runs from the top group downwards
    if (g == NUM_SLICES - 1) begin : g_head
      assign sl_en[g] = en_i;
    end else begin : g_link
      assign sl_en[g] = sl_eo[g+1];
    end

    prienc_slice #(.SLICE_W(SLICE_W)) slice_i (
      .en_i  (sl_en[g]),
      .req_i (req_i[g*SLICE_W +: SLICE_W]),
      .idx_o (sl_idx[g]),
      .gs_o  (sl_gs[g]),
      .eo_o  (sl_eo[g])
    );
  end

  prienc_merge #(.NUM_SLICES(NUM_SLICES), .SIDX_W(SIDX_W)) merge_i (
    .gs_i  (sl_gs),
    .idx_i (sl_idx),
    .idx_o (idx_o),
    .gs_o  (gs_o)
  );

  assign eo_o = sl_eo[0];
endmodule

// File: rtl/prienc_cascade_chk.sv
module prienc_cascade_chk #(
  parameter int REQ_W = 32,
  parameter int OUT_W = 5
) (
  input logic             en_i,
  input logic [REQ_W-1:0] req_i,
  input logic [OUT_W-1:0] idx_o,
  input logic             gs_o,
  input logic             eo_o
);
  always_comb begin
    if (!en_i) begin
      assert_disabled_quiet_R1: assert (idx_o == '0 && !gs_o && !eo_o)
        else $error("R1: output active while disabled");
    end
    if (en_i && req_i == '0) begin
      assert_empty_eo_R2: assert (eo_o && !gs_o && idx_o == '0)
        else $error("R2: wrong status for empty request");
    end
    if (en_i && req_i != '0) begin
      assert_hit_gs_R3: assert (gs_o && !eo_o)
        else $error("R3: wrong status for nonempty request");
    end
    assert_flags_excl_R3: assert (!(gs_o && eo_o))
      else $error("R3: gs and eo both set");
    if (gs_o) begin
      assert_idx_points_R4: assert (req_i[idx_o] == 1'b1)
        else $error("R4: index not at an active bit");
      assert_nothing_above_R4: assert (((req_i >> idx_o) >> 1) == '0)
        else $error("R4: higher active bit ignored");
    end
  end
endmodule

bind prienc_cascade prienc_cascade_chk #(.REQ_W(REQ_W), .OUT_W(OUT_W)) chk_i (
  .en_i  (en_i),
  .req_i (req_i),
  .idx_o (idx_o),
  .gs_o  (gs_o),
  .eo_o  (eo_o)
);

// File: tb/prienc_cascade_tb_top.sv
`timescale 1ns/1ps
module prienc_cascade_tb_top;
  logic        clk = 1'b0;
  logic        en;
  logic [31:0] req;
  logic [4:0]  idx;
  logic        gs, eo;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 1'b0;

  always #2.5 clk = ~clk;

  prienc_cascade dut_i (.en_i(en), .req_i(req), .idx_o(idx), .gs_o(gs), .eo_o(eo));

  // behavioural reference: scan from the top bit down
  function automatic logic [6:0] model(input logic e, input logic [31:0] r);
    logic [4:0] p;
    logic       found;
    p = 5'd0;
    found = 1'b0;
    if (e) begin
      for (int k = 31; k >= 0; k--) begin
        if (!found && r[k]) begin
          p = 5'(k);
          found = 1'b1;
        end
      end
    end
    return {p, e && found, e && !found};
  endfunction

  task automatic apply_check(input string tag, input logic e, input logic [31:0] r);
    logic [6:0] exp_v;
    @(negedge clk);
    en  = e;
    req = r;
    #1;
    exp_v = model(e, r);
    n_run++;
    if ({idx, gs, eo} !== exp_v) begin
      n_fail++;
      $display("FAIL %s: en=%0b req=%h got idx=%0d gs=%0b eo=%0b exp idx=%0d gs=%0b eo=%0b",
               tag, e, r, idx, gs, eo, exp_v[6:2], exp_v[1], exp_v[0]);
    end
  endtask

  initial begin
    en  = 1'b0;
    req = 32'h0;
    #1;
    n_run++;
    if ({idx, gs, eo} !== 7'd0) begin
      n_fail++;
      $display("FAIL R1 initial: got idx=%0d gs=%0b eo=%0b exp 0 0 0", idx, gs, eo);
    end
    // R1: disabled, various requests
    apply_check("R1", 1'b0, 32'h0);
    apply_check("R1", 1'b0, 32'hFFFF_FFFF);
    apply_check("R1", 1'b0, 32'h8000_0001);
    for (int t = 0; t < 20; t++) apply_check("R1", 1'b0, $urandom());
    // R2: enabled, empty
    apply_check("R2", 1'b1, 32'h0);
    // R6: every single bit
    for (int b = 0; b < 32; b++) apply_check("R6", 1'b1, 32'h1 << b);
    // R5/R7: exhaustive patterns per slice, others zero, no clock between drive and check
    for (int s = 0; s < 4; s++)
      for (int v = 0; v < 256; v++)
        apply_check("R7", 1'b1, 32'(v) << (8 * s));
    // R5: a high group hit masks every lower group
    for (int t = 0; t < 200; t++) begin
      logic [31:0] hi, lo;
      logic [6:0]  ref_hi;
      int          g;
      g  = 1 + int'($urandom_range(2));
      hi = 32'(1) << (8 * g + int'($urandom_range(7)));
      lo = $urandom() & ((32'(1) << (8 * g)) - 1);
      apply_check("R5", 1'b1, hi | lo);
      ref_hi = model(1'b1, hi);
      n_run++;
      if (idx !== ref_hi[6:2] || idx[4:3] !== 2'(g)) begin
        n_fail++;
        $display("FAIL R5: req=%h got idx=%0d exp idx=%0d", hi | lo, idx, ref_hi[6:2]);
      end
    end
    // R3/R4: random vectors with several active bits
    for (int t = 0; t < 2000; t++) begin
      logic [31:0] r;
      r = $urandom() & $urandom();
      if (r == 0) r = 32'h0010_0400;
      apply_check("R4", 1'b1, r);
    end
    apply_check("R3", 1'b1, 32'hFFFF_FFFF);
    apply_check("R3", 1'b1, 32'h0000_0001);
    // R1 again after activity
    apply_check("R1", 1'b0, 32'h0F0F_0F0F);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule